// File: doc/BRIEF.md
# UART FIFO DMA Request Controller

This block sits next to the receive and transmit FIFOs of a UART. It holds an 8-bit FIFO control byte and uses it to switch both FIFOs on or off together. It flushes both FIFOs whenever that switch changes. It also drives two request lines to a system DMA engine.

The receive request rises when the receive FIFO reaches a selectable fill level. It also rises when characters have been left waiting for too long, which is the character timeout. The transmit request stays high for as long as the transmit FIFO has room. Both requests work only when the FIFOs are on and the DMA-mode bit is set. The FIFO storage, the shifters, the baud generator and the DMA engine are all outside this block.

Control byte layout: bit 0 is the FIFO switch, bit 3 is the DMA mode, and bits 7:6 select the receive trigger. Bits 5:4 and 2:1 are accepted but have no function.

Top module: `uart_fifo_dmareq`

## Requirements
- R1: After reset every control bit is 0, `fifo_en` and `fifo_clr` are low, and both request outputs are low.
- R2: A control write copies `cfg_wdata[0]` to `fifo_en` at the clock edge that takes the write. `fifo_en` changes at no other time.
- R3: Bits 7:1 of the control byte are loaded only by a write whose bit 0 is 1. A write with bit 0 equal to 0 leaves the old values of bits 7:1 in place.
- R4: A write that changes bit 0, in either direction, makes `fifo_clr` high for exactly the one cycle after that write. A write that does not change bit 0 gives no pulse.
- R5: While bit 0 or bit 3 of the control byte is 0, `rx_dma_req` and `tx_dma_req` are both low.
- R6: When bits 0 and 3 are both set, `rx_dma_req` is high whenever `rx_count` is at or above the trigger level. Bits 7:6 select the trigger level: code 0 gives 1, code 1 gives 4, code 2 gives 8 and code 3 gives 14 entries.
- R7: When bits 0 and 3 are both set, `rx_dma_req` is also high after a character timeout, even if `rx_count` is below the trigger level. A timeout occurs when `rx_count` is not zero and 4 `char_tick` cycles have passed with no `rx_push` and no `rx_pop`.
- R8: The timeout count restarts on `rx_push`, on `rx_pop`, on a `fifo_clr` pulse, whenever `rx_count` is 0, and while the FIFOs are off. `rx_dma_req` falls once the count is below the trigger level and no timeout is pending.
- R9: When bits 0 and 3 are both set, `tx_dma_req` is high while `tx_count` is below 16 and low when `tx_count` is 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Control byte write strobe |
| cfg_wdata | input | 8 | Control byte write data |
| rx_count | input | 5 | Receive FIFO occupancy, 0 to 16 |
| tx_count | input | 5 | Transmit FIFO occupancy, 0 to 16 |
| char_tick | input | 1 | One-cycle pulse per character time |
| rx_push | input | 1 | A new character entered the receive FIFO |
| rx_pop | input | 1 | The receive FIFO was read |
| fifo_en | output | 1 | Both FIFOs are enabled |
| fifo_clr | output | 1 | One-cycle flush of both FIFOs |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |

## Verification
The bench first uses random control writes. These mix writes that set bit 0, writes that clear it and writes that leave it unchanged, so it can tell retained upper bits from loaded ones and toggle pulses from missing pulses. Random occupancy values, sweeping 0 to 16 under each trigger code, separate the four trigger levels at their exact boundaries. Long quiet stretches with a small non-empty receive count and sparse ticks check the timeout separately from the level path. Pushes and pops placed at the third tick check that the timeout count restarts.

// File: rtl/uart_fifo_dmareq.sv
module uart_fifo_dmareq #(
  parameter int DEPTH      = 16,
  parameter int TOUT_CHARS = 4,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int TW = $clog2(TOUT_CHARS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [7:0]    cfg_wdata,
  input  logic [CW-1:0] rx_count,
  input  logic [CW-1:0] tx_count,
  input  logic          char_tick,
  input  logic          rx_push,
  input  logic          rx_pop,
  output logic          fifo_en,
  output logic          fifo_clr,
  output logic          rx_dma_req,
  output logic          tx_dma_req
);

  logic          en_q, dma_q, clr_q;
  logic [1:0]    lvl_q;
  logic [TW-1:0] tcnt;
  logic [CW-1:0] trig;
  logic          dma_on, rx_nonempty, tout;
  logic          unused_bits;

  assign unused_bits = ^{cfg_wdata[5:4], cfg_wdata[2:1]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_q  <= 1'b0;
      dma_q <= 1'b0;
      lvl_q <= 2'd0;
      clr_q <= 1'b0;
    end else begin
      clr_q <= cfg_we && (cfg_wdata[0] != en_q);
      if (cfg_we) begin
        en_q <= cfg_wdata[0];
        if (cfg_wdata[0]) begin
          dma_q <= cfg_wdata[3];
          lvl_q <= cfg_wdata[7:6];
        end
      end
    end

  always_comb
    case (lvl_q)
      2'd0:    trig = CW'(1);
      2'd1:    trig = CW'(DEPTH / 4);
      2'd2:    trig = CW'(DEPTH / 2);
      default: trig = CW'(DEPTH - 2);
    endcase

  assign rx_nonempty = rx_count != '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      tcnt <= '0;
    else if (!en_q || !rx_nonempty || rx_push || rx_pop || clr_q)
      tcnt <= '0;
    else if (char_tick && tcnt != TW'(TOUT_CHARS))
      tcnt <= tcnt + 1'b1;

  assign tout       = rx_nonempty && tcnt == TW'(TOUT_CHARS);
  assign dma_on     = en_q && dma_q;
  assign fifo_en    = en_q;
  assign fifo_clr   = clr_q;
  assign rx_dma_req = dma_on && (rx_count >= trig || tout);
  assign tx_dma_req = dma_on && tx_count < CW'(DEPTH);

endmodule

// File: rtl/uart_fifo_dmareq_chk.sv
module uart_fifo_dmareq_chk #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic [CW-1:0] rx_count,
  input logic [CW-1:0] tx_count,
  input logic          fifo_en,
  input logic          fifo_clr,
  input logic          rx_dma_req,
  input logic          tx_dma_req,
  input logic          dma_on
);

  AST_EN_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_we) |-> $stable(fifo_en)); // R2

  AST_CLR_ON_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_en != $past(fifo_en) |-> fifo_clr); // R4

  AST_CLR_NEEDS_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |-> fifo_en != $past(fifo_en)); // R4

  AST_REQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_on |-> !rx_dma_req && !tx_dma_req); // R5

  AST_RX_TOP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    dma_on && rx_count >= CW'(DEPTH - 2) |-> rx_dma_req); // R6

  AST_RX_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count == '0 |-> !rx_dma_req); // R8

  AST_TX_FULL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    tx_count >= CW'(DEPTH) |-> !tx_dma_req); // R9

endmodule

bind uart_fifo_dmareq uart_fifo_dmareq_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .rx_count(rx_count),
  .tx_count(tx_count), .fifo_en(fifo_en), .fifo_clr(fifo_clr),
  .rx_dma_req(rx_dma_req), .tx_dma_req(tx_dma_req), .dma_on(dma_on)
);

// File: tb/uart_fifo_dmareq_tb_top.sv
`timescale 1ns/1ps
module uart_fifo_dmareq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [4:0] rx_count = '0, tx_count = '0;
  logic       char_tick = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
  logic       fifo_en, fifo_clr, rx_dma_req, tx_dma_req;

  int total = 0, bad = 0;
  logic       m_en = 0, m_dma = 0, m_clr = 0;
  logic [1:0] m_sel = 0;
  int         m_tc = 0;

  always #2 clk = ~clk;

  uart_fifo_dmareq dut_i (.*);

  function automatic int trig_of(logic [1:0] s);
    case (s) 2'd0: return 1; 2'd1: return 4; 2'd2: return 8; default: return 14; endcase
  endfunction

  function automatic logic exp_rx();
    return m_en && m_dma && (rx_count >= trig_of(m_sel) || (rx_count != 0 && m_tc == 4));
  endfunction

  task automatic check(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(logic we, logic [7:0] wd, int rc, int tc, logic tk, logic pu, logic po);
    cfg_we = we; cfg_wdata = wd; rx_count = 5'(rc); tx_count = 5'(tc);
    char_tick = tk; rx_push = pu; rx_pop = po;
    #1;
    check(m_en ? "R2" : "R1", fifo_en, m_en);
    check("R4", fifo_clr, m_clr);
    check(!(m_en && m_dma) ? "R5" : (m_tc == 4 ? "R7" : "R6"), rx_dma_req, exp_rx());
    check(!(m_en && m_dma) ? "R5" : "R9", tx_dma_req, m_en && m_dma && tc < 16);
    // model update for the coming edge
    if (!m_en || rc == 0 || pu || po || m_clr) m_tc = 0;
    else if (tk && m_tc != 4) m_tc++;
    m_clr = we && (wd[0] != m_en);
    if (we) begin
      m_en = wd[0];
      if (wd[0]) begin m_dma = wd[3]; m_sel = wd[7:6]; end
    end
    @(negedge clk);
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    @(negedge clk);
    // R1: reset state
    drive(0, 8'h00, 3, 0, 0, 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R3: upper bits ignored while disabled
    drive(1, 8'hC8, 10, 0, 0, 0, 0);
    drive(0, 8'h00, 10, 0, 0, 0, 0);
    drive(1, 8'h49, 10, 0, 0, 0, 0);   // enable, dma, trigger code 1
    for (int c = 0; c <= 16; c++) drive(0, 8'h00, c, c, 0, 0, 0); // R6, R9 boundaries
    drive(1, 8'h00, 5, 3, 0, 0, 0);    // R3 disable keeps upper bits, R4 pulse
    drive(1, 8'h01, 5, 3, 0, 0, 0);    // R3 re-enable loads dma=0 -> R5
    drive(1, 8'hC9, 5, 3, 0, 0, 0);    // code 3 = 14
    // R7: timeout with 2 entries below trigger
    for (int k = 0; k < 12; k++) drive(0, 8'h00, 2, 0, k % 2 == 0, 0, 0);
    // R8: pop restarts count, then empty clears
    for (int k = 0; k < 6; k++) drive(0, 8'h00, 2, 0, 1, 0, k == 2);
    for (int k = 0; k < 6; k++) drive(0, 8'h00, 2, 0, 1, k == 2, 0);
    drive(0, 8'h00, 0, 0, 1, 0, 0);
    for (int k = 0; k < 3; k++) drive(0, 8'h00, 1, 0, 1, 0, 0);
    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic we = ($urandom % 10) == 0;
      logic [7:0] wd = 8'($urandom);
      int quiet = (n / 200) % 2;
      int rc = quiet ? 1 + $urandom % 3 : $urandom % 17;
      if (we && ($urandom % 2)) wd[3] = 1'b1;
      drive(we, wd, rc, $urandom % 17, ($urandom % 3) == 0,
            quiet ? 1'b0 : ($urandom % 6) == 0, quiet ? 1'b0 : ($urandom % 6) == 0);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule